// File: doc/BRIEF.md
# Page Write Buffer and Timer

This block sits between a serial memory's bus front end and its storage array. After a write command names a row and a starting column, the front end pushes each received data byte into the block. Bytes land in a small row-sized buffer at a column pointer that advances after every byte and wraps inside the row, so a burst longer than the row overwrites its own earlier bytes. Each pushed byte carries a keep flag. A byte the front end refused because the write protect was active is never marked for programming.

When the front end reports a STOP that fell in the slot right after an acknowledge, the block commits the marked bytes to the array through a simple write port. It writes one byte per cycle in ascending column order. It then holds a busy flag for a self-timed programming interval whose length is a parameter in clock cycles. While busy, the front end must treat the device as absent, and the block ignores all of its command inputs. A new write start or an abort that arrives before the STOP throws the buffered bytes away. A STOP with no marked bytes starts no cycle.

Top module: `page_write_engine`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0 and no array write occurs until a committed write.
- R2: The byte pushed k-th (counting from 0) after `wr_begin` with row r and column c is written to array address r*COLS + ((c+k) mod COLS). All writes of one commit share row r.
- R3: The column wraps inside the row. When two kept bytes fall in the same column, the later one is the value written, and at most COLS writes occur per commit.
- R4: Columns of the row that received no kept byte are not written and keep their previous array contents.
- R5: A push with `push_keep`=0 is not written to the array, but it still advances the column pointer.
- R6: A `stop_ok` with no kept byte buffered (including one outside any write) raises no `busy` and produces no array write.
- R7: An `abort`, or a new `wr_begin`, before `stop_ok` discards all bytes buffered so far.
- R8: `busy` rises the cycle after an accepted `stop_ok` and stays high for exactly COLS + WRITE_CYCLES cycles. Array writes happen only while `busy` is high.
- R9: While `busy` is high, `wr_begin`, `push`, `stop_ok` and `abort` have no effect.
- R10: Commit writes are issued in ascending column order, at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_begin | input | 1 | Start of a write command; loads row and column |
| wr_row | input | ROW_BITS | Row addressed by the write |
| wr_col | input | COL_BITS | Starting column inside the row |
| push | input | 1 | One received data byte is present |
| push_data | input | DATA_W | Data byte |
| push_keep | input | 1 | 1 = byte acknowledged and to be programmed |
| stop_ok | input | 1 | STOP seen in the slot after an acknowledge |
| abort | input | 1 | START or abort; drops buffered bytes |
| busy | output | 1 | Commit and timed programming interval in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ROW_BITS+COL_BITS | Array byte address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The main function is tried with a single byte, with an overfull burst that wraps past the row end, with a short burst laid over a row written earlier, and with a mix of kept and refused bytes. These separate correct addressing from a pointer that fails to wrap or to skip refused bytes, and they show whether untouched columns are really left alone. Sequences that contain only refused bytes, an abort, or a restart show that nothing stale reaches the array. Pulsing every command input during the busy interval shows that the interval length and the array contents do not change.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_COMMIT  = 2'd2,
    ST_WAIT    = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_buffer.sv
// Row-sized byte store with per-column mark bits and a wrapping column pointer.
module pwb_buffer #(
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [COL_BITS-1:0] load_col,
  input  logic                clear,
  input  logic                push,
  input  logic [DATA_W-1:0]   push_data,
  input  logic                push_keep,
  input  logic                rd_en,
  input  logic [COL_BITS-1:0] rd_col,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_hit,
  output logic                any_marked
);
  localparam int COLS = 1 << COL_BITS;

  logic [DATA_W-1:0]   store [COLS];
  logic [COLS-1:0]     marked;
  logic [COL_BITS-1:0] ptr;
  logic                store_we;

  assign store_we   = push && push_keep;
  assign any_marked = |marked;

  // plain dual-port memory, no reset, for RAM inference
  always_ff @(posedge clk) begin
    if (store_we) store[ptr] <= push_data;
    rd_data <= store[rd_col];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      marked <= '0;
      rd_hit <= 1'b0;
    end else begin
      rd_hit <= rd_en && marked[rd_col];
      if (load) begin
        ptr    <= load_col;
        marked <= '0;
      end else if (clear) begin
        marked <= '0;
      end else if (push) begin
        ptr <= ptr + 1'b1;               // wraps inside the row
        if (push_keep) marked[ptr] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwb_timer.sv
// Self-timed programming interval, counted in clock cycles.
module pwb_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          running;

  assign done = running && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == LAST) running <= 1'b0;
      else             cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwb_seq.sv
// Command sequencer: collect, commit scan, timed wait.
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int ROW_BITS = 5,
  parameter int COL_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_begin,
  input  logic [ROW_BITS-1:0] wr_row,
  input  logic                push,
  input  logic                stop_ok,
  input  logic                abort,
  input  logic                any_marked,
  input  logic                tmr_done,
  output logic                buf_load,
  output logic                buf_clear,
  output logic                buf_push,
  output logic                scan_en,
  output logic [COL_BITS-1:0] scan_col,
  output logic [ROW_BITS-1:0] row,
  output logic                tmr_start,
  output logic                busy
);
  localparam logic [COL_BITS-1:0] LAST_COL = '1;

  pwb_state_e state, state_nx;

  always_comb begin
    state_nx  = state;
    buf_load  = 1'b0;
    buf_clear = 1'b0;
    buf_push  = 1'b0;
    tmr_start = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (wr_begin) begin
          buf_load = 1'b1;
          state_nx = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (abort) begin
          buf_clear = 1'b1;
          state_nx  = ST_IDLE;
        end else if (wr_begin) begin
          buf_load = 1'b1;
        end else if (stop_ok) begin
          if (any_marked) state_nx = ST_COMMIT;
          else            state_nx = ST_IDLE;
        end else if (push) begin
          buf_push = 1'b1;
        end
      end
      ST_COMMIT: begin
        if (scan_col == LAST_COL) begin
          tmr_start = 1'b1;
          state_nx  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tmr_done) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  assign scan_en = (state == ST_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      scan_col <= '0;
      row      <= '0;
      busy     <= 1'b0;
    end else begin
      state <= state_nx;
      busy  <= (state_nx == ST_COMMIT) || (state_nx == ST_WAIT);
      if (buf_load) row <= wr_row;
      if (state == ST_COMMIT) scan_col <= scan_col + 1'b1;
      else                    scan_col <= '0;
    end
  end
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine #(
  parameter int ROW_BITS     = 5,
  parameter int COL_BITS     = 4,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 1000000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_begin,
  input  logic [ROW_BITS-1:0]          wr_row,
  input  logic [COL_BITS-1:0]          wr_col,
  input  logic                         push,
  input  logic [DATA_W-1:0]            push_data,
  input  logic                         push_keep,
  input  logic                         stop_ok,
  input  logic                         abort,
  output logic                         busy,
  output logic                         arr_we,
  output logic [ROW_BITS+COL_BITS-1:0] arr_addr,
  output logic [DATA_W-1:0]            arr_wdata
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;

  logic                buf_load, buf_clear, buf_push;
  logic                scan_en, rd_hit, any_marked;
  logic                tmr_start, tmr_done;
  logic [COL_BITS-1:0] scan_col, scan_col_d;
  logic [ROW_BITS-1:0] row;
  logic [DATA_W-1:0]   rd_data;

  pwb_seq #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_seq (
    .clk(clk), .rst(rst), .wr_begin(wr_begin), .wr_row(wr_row),
    .push(push), .stop_ok(stop_ok), .abort(abort),
    .any_marked(any_marked), .tmr_done(tmr_done),
    .buf_load(buf_load), .buf_clear(buf_clear), .buf_push(buf_push),
    .scan_en(scan_en), .scan_col(scan_col), .row(row),
    .tmr_start(tmr_start), .busy(busy)
  );

  pwb_buffer #(.COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .load(buf_load), .load_col(wr_col),
    .clear(buf_clear), .push(buf_push), .push_data(push_data),
    .push_keep(push_keep), .rd_en(scan_en), .rd_col(scan_col),
    .rd_data(rd_data), .rd_hit(rd_hit), .any_marked(any_marked)
  );

  pwb_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .done(tmr_done)
  );

  // registered array write port, two cycles behind the scan
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_col_d <= '0;
      arr_we     <= 1'b0;
      arr_addr   <= '0;
      arr_wdata  <= '0;
    end else begin
      scan_col_d <= scan_col;
      arr_we     <= rd_hit;
      arr_addr   <= ADDR_W'({row, scan_col_d});
      arr_wdata  <= rd_data;
    end
  end
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ROW_BITS     = 5,
  parameter int COL_BITS     = 4,
  parameter int WRITE_CYCLES = 1000000
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         stop_ok,
  input logic                         busy,
  input logic                         arr_we,
  input logic [ROW_BITS+COL_BITS-1:0] arr_addr
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int SPAN   = (1 << COL_BITS) + WRITE_CYCLES;

  int run;
  always_ff @(posedge clk) begin
    if (rst)       run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  AST_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !arr_we)); // R1

  AST_WE_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |->
      (arr_addr[ADDR_W-1:COL_BITS] == $past(arr_addr[ADDR_W-1:COL_BITS]))); // R2

  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_ok)); // R8

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy); // R8

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == SPAN)); // R8

  AST_WE_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |-> (arr_addr > $past(arr_addr))); // R10
endmodule

bind page_write_engine pwb_checker #(
  .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .stop_ok(stop_ok), .busy(busy),
  .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/sim_page_write_engine.sv
`timescale 1ns/1ps
module sim_page_write_engine;
  localparam int RB = 5, CB = 4, DW = 8, WC = 40;
  localparam int COLS = 1 << CB;
  localparam int DEPTH = 1 << (RB + CB);
  localparam int SPAN = COLS + WC;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_begin = 0, push = 0, push_keep = 0, stop_ok = 0, abort = 0;
  logic [RB-1:0] wr_row = '0;
  logic [CB-1:0] wr_col = '0;
  logic [DW-1:0] push_data = '0;
  logic busy, arr_we;
  logic [RB+CB-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] expv [DEPTH];
  int wr_tot = 0;
  int log_a [64];

  always #2 clk = ~clk;

  page_write_engine #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst(rst), .wr_begin(wr_begin), .wr_row(wr_row), .wr_col(wr_col),
    .push(push), .push_data(push_data), .push_keep(push_keep), .stop_ok(stop_ok),
    .abort(abort), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  initial for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'hFF; expv[i] = 8'hFF; end

  always @(posedge clk) if (arr_we) begin
    mem[arr_addr] <= arr_wdata;
    log_a[wr_tot % 64] <= int'(arr_addr);
    wr_tot <= wr_tot + 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_array(input string req);
    int bad = 0, at = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== expv[i]) begin bad++; if (at < 0) at = i; end
    check(bad == 0, req, $sformatf("array mismatches (first at %0d)", at), bad, 0);
  endtask

  task automatic begin_w(input int r, input int c);
    @(negedge clk); wr_begin = 1; wr_row = RB'(r); wr_col = CB'(c);
    @(negedge clk); wr_begin = 0;
  endtask

  task automatic push_b(input logic [7:0] d, input bit k);
    @(negedge clk); push = 1; push_data = d; push_keep = k;
    @(negedge clk); push = 0;
  endtask

  task automatic commit(output int n);
    @(negedge clk); stop_ok = 1;
    @(negedge clk); stop_ok = 0;
    n = 0;
    while (busy && n < 100000) begin n++; @(negedge clk); end
    repeat (3) @(negedge clk);
  endtask

  task automatic stop_expect_none(input string req);
    int hi = 0;
    @(negedge clk); stop_ok = 1;
    @(negedge clk); stop_ok = 0;
    for (int i = 0; i < 6; i++) begin if (busy) hi++; @(negedge clk); end
    check(hi == 0, req, "busy cycles after stop", hi, 0);
  endtask

  task automatic t_reset;
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(arr_we == 0, "R1", "arr_we after reset", arr_we, 0);
    check(wr_tot == 0, "R1", "writes after reset", wr_tot, 0);
  endtask

  task automatic t_single;
    int base = wr_tot, n;
    begin_w(3, 5); push_b(8'hA5, 1);
    expv[3*COLS + 5] = 8'hA5;
    commit(n);
    check(n == SPAN, "R8", "busy length", n, SPAN);
    check(wr_tot - base == 1, "R2", "write count", wr_tot - base, 1);
    check_array("R2");
  endtask

  task automatic t_wrap;
    int base = wr_tot, n;
    begin_w(7, 14);
    for (int i = 0; i < 18; i++) begin
      push_b(8'(8'h10 + i), 1);
      expv[7*COLS + ((14 + i) % COLS)] = 8'(8'h10 + i);
    end
    commit(n);
    check(wr_tot - base == COLS, "R3", "write count", wr_tot - base, COLS);
    check_array("R3");
    check(log_a[base % 64] == 7*COLS, "R10", "first address", log_a[base % 64], 7*COLS);
    check(log_a[(base + COLS - 1) % 64] == 7*COLS + COLS - 1, "R10", "last address",
          log_a[(base + COLS - 1) % 64], 7*COLS + COLS - 1);
  endtask

  task automatic t_partial;
    int base = wr_tot, n;
    begin_w(7, 2);
    for (int i = 0; i < 3; i++) begin
      push_b(8'(8'h60 + i), 1);
      expv[7*COLS + 2 + i] = 8'(8'h60 + i);
    end
    commit(n);
    check(wr_tot - base == 3, "R4", "write count", wr_tot - base, 3);
    check_array("R4");
  endtask

  task automatic t_protect;
    int base = wr_tot, n;
    begin_w(9, 0);
    push_b(8'hC0, 1); push_b(8'hC1, 0); push_b(8'hC2, 1);
    expv[9*COLS + 0] = 8'hC0;
    expv[9*COLS + 2] = 8'hC2;
    commit(n);
    check(wr_tot - base == 2, "R5", "write count", wr_tot - base, 2);
    check_array("R5");
  endtask

  task automatic t_none_kept;
    int base = wr_tot;
    begin_w(10, 0); push_b(8'h11, 0); push_b(8'h22, 0);
    stop_expect_none("R6");
    stop_expect_none("R6");
    check(wr_tot == base, "R6", "write count", wr_tot - base, 0);
    check_array("R6");
  endtask

  task automatic t_discard;
    int base = wr_tot, n;
    begin_w(11, 0); push_b(8'h5A, 1);
    @(negedge clk); abort = 1; @(negedge clk); abort = 0;
    stop_expect_none("R7");
    check(wr_tot == base, "R7", "writes after abort", wr_tot - base, 0);
    begin_w(12, 0); push_b(8'hAA, 1);
    begin_w(13, 1); push_b(8'hBB, 1);
    expv[13*COLS + 1] = 8'hBB;
    commit(n);
    check(wr_tot - base == 1, "R7", "writes after restart", wr_tot - base, 1);
    check_array("R7");
  endtask

  task automatic t_busy_ignore;
    int base = wr_tot, n = 0;
    begin_w(14, 0); push_b(8'h77, 1);
    expv[14*COLS] = 8'h77;
    @(negedge clk); stop_ok = 1;
    @(negedge clk); stop_ok = 0;
    while (busy && n < 100000) begin
      n++;
      wr_begin = (n == 3); wr_row = 5'd15; wr_col = '0;
      push = (n >= 4 && n <= 6); push_data = 8'h99; push_keep = 1;
      stop_ok = (n == 8); abort = (n == 10);
      @(negedge clk);
    end
    wr_begin = 0; push = 0; stop_ok = 0; abort = 0;
    repeat (3) @(negedge clk);
    check(n == SPAN, "R9", "busy length with traffic", n, SPAN);
    check(wr_tot - base == 1, "R9", "write count", wr_tot - base, 1);
    stop_expect_none("R9");
    check_array("R9");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_single;
    t_wrap;
    t_partial;
    t_protect;
    t_none_kept;
    t_discard;
    t_busy_ignore;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule